// File: doc/BRIEF.md
# DC-Balanced Frame Encoder

This block turns 20-bit data fields into 24-bit line frames that keep the serial stream DC balanced. Each field arrives with a flag that marks it as the first or second half of a 40-bit word. The encoder adds a 4-bit coding nibble that carries that flag and a fixed mid-nibble transition. Three command inputs from the link-control logic choose what goes out in each frame slot: a data frame, a balanced idle pattern (fill type 0), or a fill type 1 pattern that is one step heavy or light.

A running disparity register holds ones minus zeros over everything sent so far. For each data frame the encoder finds the frame's own balance. When that balance has the same sign as the running disparity, it sends the complement of the whole frame. For fill type 1 it picks the light pattern when the disparity is zero or above, and the heavy pattern when it is below zero. The disparity is cleared when the fill type 0 command is released. The result is registered and is shown twice: as a 24-bit word in transmission order, and reversed for a shifter that sends its most significant bit first.

Top module: `dcb_frame_encoder`

## Requirements
- R1: While reset is active and after it is released with no command, `frameValid` is 0 and `frameOut` and `serialOut` are all zeros. The running disparity starts at 0.
- R2: A data frame carries the field in bits 0..19 of `frameOut`, followed by the nibble in bits 20..23 (bit index equals transmission order). With flag 0 the nibble bits 20..23 are 1,1,0,1. With flag 1 they are 1,0,1,1. Bits 21 and 22 always differ in every valid frame.
- R3: For a data frame, the balance is 2·(ones in the 24-bit frame) − 24. If the sign of that balance equals the sign of the running disparity, all 24 bits are complemented, and otherwise they are sent as they are. Zero counts as positive for both values.
- R4: Fill type 0 sends bits 0..9 as 1, bits 10..19 as 0 and nibble bits 20..23 as 0,0,1,1. That gives 12 ones and 12 zeros.
- R5: Fill type 1 uses nibble bits 20..23 = 0,0,1,1. The light form has bits 0..8 set and the rest of the field clear. The heavy form has bits 0..10 set. Light is sent when the running disparity is zero or above, and heavy when it is below zero.
- R6: After every sent frame, the running disparity moves by ones minus zeros of the bits actually sent, and saturates at ±31. In the cycle where `sendFill0` goes from 1 to 0, the disparity is first reset to 0.
- R7: When several commands are active, fill type 0 wins over fill type 1, and fill type 1 wins over data.
- R8: A cycle with no command gives `frameValid` = 0 and leaves the running disparity unchanged, apart from a clear caused by R6. The field and flag inputs are then ignored.
- R9: `serialOut` is `frameOut` in reversed bit order: `serialOut[23]` is the first bit sent (field bit 0) and `serialOut[0]` is the last nibble bit.
- R10: A command sampled at one rising edge shows its frame on `frameOut` and `frameValid` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fieldIn | input | 20 | Data field for a data frame |
| fieldFlag | input | 1 | 0 = first field of the word, 1 = second |
| sendData | input | 1 | Command: send a data frame |
| sendFill0 | input | 1 | Command: send fill type 0 |
| sendFill1 | input | 1 | Command: send fill type 1 |
| frameOut | output | 24 | Frame, bit index = transmission order |
| serialOut | output | 24 | Frame reversed, MSB sent first |
| frameValid | output | 1 | A frame was produced this slot |

## Verification
Every result has a latency of exactly one register stage. A command applied between two rising edges produces its frame, or its missing valid strobe, just after the next edge. The disparity it leaves behind only becomes visible through the choice made for the following frame. The driver applies stimulus just after a rising edge and pushes the expected frame into a queue. The monitor compares at the falling edge that follows the capturing edge, so each comparison pairs the second-newest queue entry with the output. Disparity effects, including the clear when fill type 0 is released and the hold during idle slots, are checked through the inversion and heavy/light choices of later frames.

// File: rtl/dcb_enc_pkg.sv
package dcb_enc_pkg;
  // Strobes from control to datapath, at most one select active.
  typedef struct packed {
    logic selData;
    logic selFill0;
    logic selFill1;
    logic clearDisp;
  } enc_strobe_t;
endpackage

// File: rtl/dcb_enc_ctrl.sv
module dcb_enc_ctrl
  import dcb_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sendData,
  input  logic        sendFill0,
  input  logic        sendFill1,
  output enc_strobe_t strobe
);
  logic prevFill0;

  always_ff @(posedge clk) begin
    if (!rst_n) prevFill0 <= 1'b0;
    else        prevFill0 <= sendFill0;
  end

  // Priority: fill 0, then fill 1, then data (R7)
  always_comb begin
    strobe.selFill0  = sendFill0;
    strobe.selFill1  = !sendFill0 && sendFill1;
    strobe.selData   = !sendFill0 && !sendFill1 && sendData;
    strobe.clearDisp = prevFill0 && !sendFill0;
  end

  a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.selData, strobe.selFill0, strobe.selFill1}));
  a_r7_fill0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sendFill0 |-> (strobe.selFill0 && !strobe.selData && !strobe.selFill1));
endmodule

// File: rtl/dcb_enc_datapath.sv
module dcb_enc_datapath
  import dcb_enc_pkg::*;
#(
  parameter int FIELD_W  = 20,
  parameter int DISP_LIM = 31
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  enc_strobe_t            strobe,
  input  logic [FIELD_W-1:0]     fieldIn,
  input  logic                   fieldFlag,
  output logic [FIELD_W+3:0]     frameOut,
  output logic                   frameValid
);
  localparam int FRAME_W = FIELD_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int DISP_W  = $clog2(DISP_LIM + 1) + 1;
  localparam int SUM_W   = ((DISP_W > CNT_W) ? DISP_W : CNT_W) + 2;
  localparam int HALF    = FIELD_W / 2;

  // Nibble vectors, bit k = nibble bit sent k-th
  localparam logic [3:0] NIB_FIRST  = 4'b1011;
  localparam logic [3:0] NIB_SECOND = 4'b1101;
  localparam logic [3:0] NIB_FILL   = 4'b1100;

  localparam logic [FIELD_W-1:0] ALL_ONES    = {FIELD_W{1'b1}};
  localparam logic [FIELD_W-1:0] FILL0_FIELD = ALL_ONES >> (FIELD_W - HALF);
  localparam logic [FIELD_W-1:0] HEAVY_FIELD = ALL_ONES >> (FIELD_W - HALF - 1);
  localparam logic [FIELD_W-1:0] LIGHT_FIELD = ALL_ONES >> (FIELD_W - HALF + 1);

  localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'(DISP_LIM);
  localparam logic signed [SUM_W-1:0] NEG_LIM = -POS_LIM;

  function automatic logic [CNT_W-1:0] onesOf(input logic [FRAME_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < FRAME_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic signed [DISP_W-1:0] disp, effDisp, dispNext;
  logic [FRAME_W-1:0]       rawData, chosen;
  logic signed [SUM_W-1:0]  rawBal, sentBal, sum, sumSat;
  logic                     dispNonNeg, invertData, anySel;

  always_comb begin
    anySel     = strobe.selData || strobe.selFill0 || strobe.selFill1;
    effDisp    = strobe.clearDisp ? '0 : disp;
    dispNonNeg = !effDisp[DISP_W-1];
    rawData    = {(fieldFlag ? NIB_SECOND : NIB_FIRST), fieldIn};
    rawBal     = SUM_W'({onesOf(rawData), 1'b0}) - SUM_W'(FRAME_W);
    invertData = (!rawBal[SUM_W-1]) == dispNonNeg;

    if (strobe.selFill0)      chosen = {NIB_FILL, FILL0_FIELD};
    else if (strobe.selFill1) chosen = dispNonNeg ? {NIB_FILL, LIGHT_FIELD}
                                                  : {NIB_FILL, HEAVY_FIELD};
    else                      chosen = invertData ? ~rawData : rawData;

    sentBal  = SUM_W'({onesOf(chosen), 1'b0}) - SUM_W'(FRAME_W);
    sum      = {{(SUM_W-DISP_W){effDisp[DISP_W-1]}}, effDisp} + sentBal;
    sumSat   = (sum > POS_LIM) ? POS_LIM : ((sum < NEG_LIM) ? NEG_LIM : sum);
    dispNext = anySel ? sumSat[DISP_W-1:0] : effDisp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp       <= '0;
      frameOut   <= '0;
      frameValid <= 1'b0;
    end else begin
      disp       <= dispNext;
      frameValid <= anySel;
      if (anySel) frameOut <= chosen;
    end
  end

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!anySel && !strobe.clearDisp) |=> $stable(disp));
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    anySel |=> frameValid);
  a_r8_idle_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !anySel |=> !frameValid);
  a_r2_master_transition: assert property (@(posedge clk) disable iff (!rst_n)
    frameValid |-> (frameOut[FIELD_W+1] != frameOut[FIELD_W+2]));
  a_r6_disp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ((SUM_W'(disp) <= SUM_W'(FRAME_W)) && (SUM_W'(disp) >= -SUM_W'(FRAME_W))));
endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder
  import dcb_enc_pkg::*;
#(
  parameter int FIELD_W  = 20,
  parameter int DISP_LIM = 31
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FIELD_W-1:0]   fieldIn,
  input  logic                 fieldFlag,
  input  logic                 sendData,
  input  logic                 sendFill0,
  input  logic                 sendFill1,
  output logic [FIELD_W+3:0]   frameOut,
  output logic [FIELD_W+3:0]   serialOut,
  output logic                 frameValid
);
  localparam int FRAME_W = FIELD_W + 4;

  enc_strobe_t strobe;

  dcb_enc_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sendData(sendData), .sendFill0(sendFill0), .sendFill1(sendFill1),
    .strobe(strobe)
  );

  dcb_enc_datapath #(.FIELD_W(FIELD_W), .DISP_LIM(DISP_LIM)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .fieldIn(fieldIn), .fieldFlag(fieldFlag),
    .frameOut(frameOut), .frameValid(frameValid)
  );

  // R9: reversed view for an MSB-first shifter
  for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
    assign serialOut[FRAME_W-1-i] = frameOut[i];
  end
endmodule

// File: tb/test_dcb_frame_encoder.sv
module test_dcb_frame_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] fieldIn = '0;
  logic        fieldFlag = 1'b0;
  logic        sendData = 1'b0, sendFill0 = 1'b0, sendFill1 = 1'b0;
  logic [23:0] frameOut, serialOut;
  logic        frameValid;

  always #2.5 clk = ~clk;

  dcb_frame_encoder i_dcb_frame_encoder (
    .clk(clk), .rst_n(rst_n), .fieldIn(fieldIn), .fieldFlag(fieldFlag),
    .sendData(sendData), .sendFill0(sendFill0), .sendFill1(sendFill1),
    .frameOut(frameOut), .serialOut(serialOut), .frameValid(frameValid)
  );

  typedef struct {
    logic        valid;
    logic [23:0] frame;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   bd = 0;          // bench model of running disparity
  logic prevF0 = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;
  bit   done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit d, input bit f0, input bit f1,
                      input logic [19:0] fld, input bit flg, input string tag);
    exp_t e;
    logic [23:0] raw;
    int bal;
    @(posedge clk); #1;
    sendData = d; sendFill0 = f0; sendFill1 = f1; fieldIn = fld; fieldFlag = flg;
    if (prevF0 && !f0) bd = 0;      // R6 clear on fill 0 release
    prevF0 = f0;
    e.valid = d | f0 | f1; e.tag = tag; e.frame = '0;
    if (f0) e.frame = {4'b1100, 20'h003FF};
    else if (f1) e.frame = (bd >= 0) ? {4'b1100, 20'h001FF} : {4'b1100, 20'h007FF};
    else if (d) begin
      raw = {(flg ? 4'b1101 : 4'b1011), fld};
      bal = 2 * $countones(raw) - 24;
      e.frame = (((bal >= 0) == (bd >= 0)) ? ~raw : raw);
    end
    if (e.valid) begin
      bd = bd + 2 * $countones(e.frame) - 24;
      if (bd > 31) bd = 31;
      if (bd < -31) bd = -31;
    end
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() >= 2) begin
      exp_t e;
      logic [23:0] rev;
      e = q.pop_front();
      check(frameValid === e.valid, e.tag, "valid", {23'b0, frameValid}, {23'b0, e.valid});
      if (e.valid) begin
        for (int i = 0; i < 24; i++) rev[23-i] = e.frame[i];
        check(frameOut === e.frame, e.tag, "frameOut", frameOut, e.frame);
        check(serialOut === rev, "R9", "serialOut", serialOut, rev);
      end
    end
  end

  initial begin
    #300000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(frameValid === 1'b0, "R1", "valid in reset", {23'b0, frameValid}, 24'h0);
    check(frameOut === 24'h0, "R1", "frame in reset", frameOut, 24'h0);
    check(serialOut === 24'h0, "R1", "serial in reset", serialOut, 24'h0);
    rst_n = 1'b1;
    step(0, 0, 0, 20'hABCDE, 1, "R1");
    step(0, 0, 0, 20'h0, 0, "R8");
    // R2/R3 starting at disparity 0 (positive)
    step(1, 0, 0, 20'h00000, 0, "R2");
    step(1, 0, 0, 20'hFFFFF, 1, "R3");
    step(1, 0, 0, 20'hFFFFF, 0, "R3");
    step(1, 0, 0, 20'h00000, 1, "R2");
    // R4 fill 0 repeated
    step(0, 1, 0, 20'h12345, 0, "R4");
    step(0, 1, 0, 20'h12345, 1, "R4");
    // R5 fill 1 after clear, toggling light/heavy
    for (int i = 0; i < 6; i++) step(0, 0, 1, 20'h0, 0, "R5");
    // R3 mixed fields
    for (int i = 0; i < 40; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(1, 0, 0, lfsr[19:0], lfsr[27], "R3");
    end
    // R6: drive disparity negative, hold fill 0, release into fill 1 -> light expected
    step(1, 0, 0, 20'h00000, 0, "R3");
    step(0, 1, 0, 20'h0, 0, "R4");
    step(0, 0, 1, 20'h0, 0, "R6");
    // R6 clear on release into idle, then fill 1 decision
    step(1, 0, 0, 20'h00000, 0, "R3");
    step(0, 1, 0, 20'h0, 0, "R4");
    step(0, 0, 0, 20'h0, 0, "R8");
    step(0, 0, 1, 20'h0, 0, "R6");
    // R8: idle with junk then decision shows unchanged disparity
    step(1, 0, 0, 20'h00000, 0, "R3");
    step(0, 0, 0, 20'hFFFFF, 1, "R8");
    step(0, 0, 0, 20'h5A5A5, 0, "R8");
    step(0, 0, 1, 20'h0, 0, "R8");
    step(1, 0, 0, 20'h00F00, 1, "R8");
    // R7 priority
    step(1, 1, 1, 20'hFFFFF, 1, "R7");
    step(1, 0, 1, 20'hFFFFF, 1, "R7");
    step(1, 0, 1, 20'h00000, 0, "R7");
    step(1, 1, 0, 20'h00000, 0, "R7");
    step(1, 0, 0, 20'h0F0F0, 0, "R10");
    step(0, 0, 0, 20'h0, 0, "R10");
    step(0, 0, 0, 20'h0, 0, "R10");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule